// File: doc/BRIEF.md
# Float to Integer Rounding Unit

This block takes a 32-bit single-precision floating-point word and returns a 32-bit two's-complement integer, rounded in one of four directions. The direction comes from a small mode register inside the block. Reset sets it to round-to-nearest-even, and a write strobe changes it. A one-cycle start pulse begins a conversion.

The significand is aligned to the integer point a few bit positions per clock. This keeps each cycle's logic shallow, and the conversion takes a bounded number of cycles. Bits shifted below the integer point are kept as a guard bit and a sticky bit, and these decide the rounding and the inexact flag.

NaN, infinity and any value whose rounded result would fall outside the signed 32-bit range do not give a number. They return the indefinite integer 80000000h and raise the invalid flag. The result and both flags are registered. They hold steady until the next conversion finishes, and the done output pulses for one cycle when they are updated.

Top module: `f2i_round_unit`

## Requirements
- R1: After reset the mode register holds 00. A cycle with `mode_we_i` high loads `mode_i` into it. The encodings are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The mode is captured when a conversion starts.
- R2: In mode 00 the result is the nearest integer, and an exact half goes to the even neighbour (2.5 gives 2, 3.5 gives 4, 5.64 gives 6).
- R3: In mode 01 the result is the largest integer not above the operand (-2.5 gives -3, 2.5 gives 2).
- R4: In mode 10 the result is the smallest integer not below the operand (2.5 gives 3, -2.5 gives -2).
- R5: In mode 11 the fraction is dropped and the magnitude never grows (-2.5 gives -2, 2.5 gives 2).
- R6: `inexact_o` is 1 exactly when some bit below the integer point is nonzero. Integer-valued operands give 0.
- R7: These operands return 80000000h with `invalid_o` = 1 and `inexact_o` = 0: an exponent field of all ones (NaN or infinity), or any magnitude of 2^31 or more other than exactly -2^31.
- R8: Exactly -2^31 (CF000000h) converts to 80000000h with neither flag set. 4EFFFFFFh converts to 7FFFFF80h.
- R9: `done_o` is high for exactly one cycle per accepted start. A start that arrives while a conversion is in progress is ignored. The result and flags change only in the cycle that `done_o` is high.
- R10: Zero of either sign gives 0 with no flags. A denormal operand gives 0 or ±1 according to the mode, with `inexact_o` set.
- R11: `done_o` rises no more than ceil(25/STEP)+2 clock edges after the edge that samples start (9 edges with the default STEP of 4).

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Load `mode_i` into the rounding-mode register |
| mode_i | input | 2 | New rounding mode |
| start_i | input | 1 | Begin a conversion of `operand_i` (ignored while busy) |
| operand_i | input | 32 | Single-precision operand |
| result_o | output | 32 | Signed integer result |
| done_o | output | 1 | One-cycle pulse when the result and flags update |
| invalid_o | output | 1 | Operand was NaN, infinite or out of range |
| inexact_o | output | 1 | Discarded fraction was nonzero |

## Verification
Operands placed exactly on a half separate the four directions from one another. They also separate ties-to-even from a plain round-half-up, while above-half and below-half operands confirm that the guard and sticky bits are gathered correctly. The edges of the range are tried directly: -2^31 against +2^31, the largest value that fits, and the smallest denormal under each mode. These catch errors in the exponent limit and the sign handling. Random operands whose exponents fall across the whole right-shift and left-shift span, in random modes, are compared with an integer-division model. A start issued while the unit is busy shows whether the unit is free to be restarted only once it has finished.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_FIN
  } cvt_state_e;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  parameter int CNT_W  = 6
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output logic                  sign_o,
  output logic                  special_o,
  output logic                  left_o,
  output logic [CNT_W-1:0]      count_o,
  output logic [FRAC_W:0]       sig_o
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXACT_E = BIAS + FRAC_W;       // exponent where ulp == 1
  localparam int LIMIT_E = BIAS + INT_W - 1;    // 2^(INT_W-1)
  localparam int MAX_RSH = FRAC_W + 2;          // further shifts change nothing
  localparam int ALL1    = (1 << EXP_W) - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              min_neg;
  int                e_int;

  always_comb begin
    exp_f   = op_i[FRAC_W +: EXP_W];
    frac_f  = op_i[FRAC_W-1:0];
    sign_o  = op_i[EXP_W+FRAC_W];
    e_int   = (exp_f == '0) ? 1 : int'(exp_f);
    sig_o   = {exp_f != '0, frac_f};
    min_neg = sign_o && (e_int == LIMIT_E) && (frac_f == '0);
    special_o = (int'(exp_f) == ALL1) || ((e_int >= LIMIT_E) && !min_neg);
    left_o  = (e_int >= EXACT_E);
    if (left_o)
      count_o = CNT_W'(e_int - EXACT_E);
    else if ((EXACT_E - e_int) > MAX_RSH)
      count_o = CNT_W'(MAX_RSH);
    else
      count_o = CNT_W'(EXACT_E - e_int);
  end
endmodule

// File: rtl/f2i_align_step.sv
module f2i_align_step #(
  parameter int INT_W = 32,
  parameter int STEP  = 4,
  parameter int CNT_W = 6
) (
  input  logic [INT_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             left_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [INT_W-1:0] mag_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic [CNT_W-1:0] rem_o
);
  always_comb begin
    mag_o    = mag_i;
    guard_o  = guard_i;
    sticky_o = sticky_i;
    for (int i = 0; i < STEP; i++) begin
      if (CNT_W'(i) < rem_i) begin
        if (left_i) begin
          mag_o = {mag_o[INT_W-2:0], 1'b0};
        end else begin
          sticky_o = sticky_o | guard_o;
          guard_o  = mag_o[0];
          mag_o    = {1'b0, mag_o[INT_W-1:1]};
        end
      end
    end
    rem_o = (rem_i > CNT_W'(STEP)) ? rem_i - CNT_W'(STEP) : '0;
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] mag_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  rmode_e           mode_i,
  output logic [INT_W-1:0] value_o,
  output logic             inexact_o
);
  logic             bump;
  logic [INT_W-1:0] sum;

  always_comb begin
    inexact_o = guard_i | sticky_i;
    unique case (mode_i)
      RM_NEAR: bump = guard_i & (sticky_i | mag_i[0]);
      RM_DOWN: bump = sign_i & inexact_o;
      RM_UP:   bump = ~sign_i & inexact_o;
      default: bump = 1'b0;
    endcase
    sum     = mag_i + {{(INT_W-1){1'b0}}, bump};
    value_o = sign_i ? (~sum + 1'b1) : sum;
  end
endmodule

// File: rtl/f2i_round_unit.sv
module f2i_round_unit
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  parameter int STEP   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_we_i,
  input  logic [1:0]              mode_i,
  input  logic                    start_i,
  input  logic [EXP_W+FRAC_W:0]   operand_i,
  output logic [INT_W-1:0]        result_o,
  output logic                    done_o,
  output logic                    invalid_o,
  output logic                    inexact_o
);
  localparam int SIG_W   = FRAC_W + 1;
  localparam int CNT_W   = $clog2(FRAC_W + INT_W + 3);
  localparam int MAX_RSH = FRAC_W + 2;
  localparam int LAT_MAX = (MAX_RSH + STEP - 1) / STEP + 2;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  cvt_state_e       state;
  rmode_e           mode_q, mode_lat;
  logic             sign_q, left_q, inv_q, guard_q, sticky_q;
  logic [CNT_W-1:0] cnt_q;
  logic [INT_W-1:0] mag_q;

  logic             c_sign, c_special, c_left;
  logic [CNT_W-1:0] c_count;
  logic [SIG_W-1:0] c_sig;
  logic [INT_W-1:0] s_mag;
  logic             s_guard, s_sticky;
  logic [CNT_W-1:0] s_rem;
  logic [INT_W-1:0] r_value;
  logic             r_inexact;

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .CNT_W(CNT_W)) u_classify (
    .op_i(operand_i), .sign_o(c_sign), .special_o(c_special), .left_o(c_left),
    .count_o(c_count), .sig_o(c_sig)
  );

  f2i_align_step #(.INT_W(INT_W), .STEP(STEP), .CNT_W(CNT_W)) u_step (
    .mag_i(mag_q), .guard_i(guard_q), .sticky_i(sticky_q), .left_i(left_q), .rem_i(cnt_q),
    .mag_o(s_mag), .guard_o(s_guard), .sticky_o(s_sticky), .rem_o(s_rem)
  );

  f2i_round #(.INT_W(INT_W)) u_round (
    .mag_i(mag_q), .guard_i(guard_q), .sticky_i(sticky_q), .sign_i(sign_q),
    .mode_i(mode_lat), .value_o(r_value), .inexact_o(r_inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RM_NEAR;
    end else if (mode_we_i) begin
      mode_q <= rmode_e'(mode_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_lat  <= RM_NEAR;
      sign_q    <= 1'b0;
      left_q    <= 1'b0;
      inv_q     <= 1'b0;
      guard_q   <= 1'b0;
      sticky_q  <= 1'b0;
      cnt_q     <= '0;
      mag_q     <= '0;
      result_o  <= '0;
      done_o    <= 1'b0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          mode_lat <= mode_q;
          sign_q   <= c_sign;
          left_q   <= c_left;
          inv_q    <= c_special;
          guard_q  <= 1'b0;
          sticky_q <= 1'b0;
          cnt_q    <= c_count;
          mag_q    <= {{(INT_W-SIG_W){1'b0}}, c_sig};
          state    <= (c_special || c_count == '0) ? ST_FIN : ST_SHIFT;
        end
        ST_SHIFT: begin
          mag_q    <= s_mag;
          guard_q  <= s_guard;
          sticky_q <= s_sticky;
          cnt_q    <= s_rem;
          if (s_rem == '0) state <= ST_FIN;
        end
        default: begin
          done_o    <= 1'b1;
          result_o  <= inv_q ? INDEF : r_value;
          invalid_o <= inv_q;
          inexact_o <= !inv_q && r_inexact;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // Latency watch for the R11 bound
  logic [7:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) busy_cnt <= '0;
    else                         busy_cnt <= busy_cnt + 8'd1;
  end

  assert_mode_reset_R1: assert property (@(posedge clk) rst |=> (mode_q == RM_NEAR));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));
  assert_indef_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && invalid_o) |-> (result_o == INDEF && !inexact_o));
  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= 8'(LAT_MAX));
endmodule

// File: tb/f2i_round_unit_bench.sv
`timescale 1ns/1ps
module f2i_round_unit_bench;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode_we_i;
  logic [1:0]  mode_i;
  logic        start_i;
  logic [31:0] operand_i;
  logic [31:0] result_o;
  logic        done_o, invalid_o, inexact_o;

  int n_checks = 0;
  int n_err    = 0;

  always #(CLK_NS/2) clk = ~clk;

  f2i_round_unit u_f2i_round_unit (
    .clk(clk), .rst(rst), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .start_i(start_i), .operand_i(operand_i), .result_o(result_o),
    .done_o(done_o), .invalid_o(invalid_o), .inexact_o(inexact_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Integer-division model of the conversion
  task automatic model(input logic [31:0] op, input logic [1:0] md,
                       output logic [31:0] res, output logic inv, output logic inx);
    logic s;
    int   e, p, sh;
    longint m, q, r, half, mag;
    logic inc;
    s = op[31]; e = int'(op[30:23]);
    m = (e == 0) ? longint'(op[22:0]) : (longint'(1) << 23) | longint'(op[22:0]);
    p = ((e == 0) ? 1 : e) - 150;
    inv = 1'b0; inx = 1'b0; res = 32'h0;
    if (e == 255) begin
      inv = 1'b1; res = 32'h8000_0000;
    end else if (p >= 8) begin
      res = 32'h8000_0000;
      inv = !(s && p == 8 && op[22:0] == 0);
    end else if (p >= 0) begin
      mag = m << p;
      res = s ? 32'(-mag) : 32'(mag);
    end else begin
      sh = -p; if (sh > 40) sh = 40;
      q = m >> sh; r = m - (q << sh); half = longint'(1) << (sh - 1);
      inx = (r != 0);
      case (md)
        2'b00:   inc = (r > half) || (r == half && q[0]);
        2'b01:   inc = s && inx;
        2'b10:   inc = !s && inx;
        default: inc = 1'b0;
      endcase
      mag = q + longint'(inc);
      res = s ? 32'(-mag) : 32'(mag);
    end
  endtask

  task automatic set_mode(input logic [1:0] md);
    @(negedge clk); mode_we_i = 1'b1; mode_i = md;
    @(negedge clk); mode_we_i = 1'b0;
  endtask

  task automatic run_conv(input logic [31:0] op, output int waited);
    @(negedge clk); operand_i = op; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 60) begin @(negedge clk); waited++; end
  endtask

  task automatic try_op(input string tag, input logic [31:0] op, input logic [1:0] md);
    logic [31:0] er; logic ei, ex; int w;
    model(op, md, er, ei, ex);
    run_conv(op, w);
    check({tag, " done"}, {31'b0, done_o}, 32'd1);
    check({tag, " result"}, result_o, er);
    check({tag, " invalid"}, {31'b0, invalid_o}, {31'b0, ei});
    check({tag, " inexact"}, {31'b0, inexact_o}, {31'b0, ex});
    check("R11 latency bound", {31'b0, (w <= 8)}, 32'd1);
  endtask

  task automatic try_exp(input string tag, input logic [31:0] op, input logic [1:0] md,
                         input logic [31:0] er, input logic ei, input logic ex);
    int w;
    set_mode(md);
    run_conv(op, w);
    check({tag, " result"}, result_o, er);
    check({tag, " invalid"}, {31'b0, invalid_o}, {31'b0, ei});
    check({tag, " inexact"}, {31'b0, inexact_o}, {31'b0, ex});
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int w, seen;
    logic [31:0] op;
    logic [1:0]  md;
    void'($urandom(32'h5eed_0c11));
    rst = 1'b1; mode_we_i = 1'b0; mode_i = 2'b00; start_i = 1'b0; operand_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R9 reset result", result_o, 32'h0);
    check("R9 reset done", {31'b0, done_o}, 32'd0);
    check("R7 reset invalid", {31'b0, invalid_o}, 32'd0);
    check("R6 reset inexact", {31'b0, inexact_o}, 32'd0);

    // R1 default mode without any write: ties to even
    run_conv(32'h4020_0000, w);
    check("R1 default 2.5", result_o, 32'd2);
    run_conv(32'h4060_0000, w);
    check("R1 default 3.5", result_o, 32'd4);

    // R2 nearest-even
    try_exp("R2 5.64", 32'h40B4_7AE1, 2'b00, 32'd6, 1'b0, 1'b1);
    try_exp("R2 -3.5", 32'hC060_0000, 2'b00, 32'hFFFF_FFFC, 1'b0, 1'b1);
    try_exp("R2 1.4375", 32'h3FB8_0000, 2'b00, 32'd1, 1'b0, 1'b1);
    // R3 toward minus infinity
    try_exp("R3 2.5", 32'h4020_0000, 2'b01, 32'd2, 1'b0, 1'b1);
    try_exp("R3 -2.5", 32'hC020_0000, 2'b01, 32'hFFFF_FFFD, 1'b0, 1'b1);
    // R4 toward plus infinity
    try_exp("R4 2.5", 32'h4020_0000, 2'b10, 32'd3, 1'b0, 1'b1);
    try_exp("R4 -2.5", 32'hC020_0000, 2'b10, 32'hFFFF_FFFE, 1'b0, 1'b1);
    // R5 toward zero
    try_exp("R5 2.75", 32'h4030_0000, 2'b11, 32'd2, 1'b0, 1'b1);
    try_exp("R5 -2.5", 32'hC020_0000, 2'b11, 32'hFFFF_FFFE, 1'b0, 1'b1);
    // R6 exact values
    try_exp("R6 1.0", 32'h3F80_0000, 2'b10, 32'd1, 1'b0, 1'b0);
    try_exp("R6 -10.0", 32'hC120_0000, 2'b01, 32'hFFFF_FFF6, 1'b0, 1'b0);
    // R7 invalid cases
    try_exp("R7 NaN", 32'h7FC0_0000, 2'b00, 32'h8000_0000, 1'b1, 1'b0);
    try_exp("R7 +inf", 32'h7F80_0000, 2'b00, 32'h8000_0000, 1'b1, 1'b0);
    try_exp("R7 2^31", 32'h4F00_0000, 2'b11, 32'h8000_0000, 1'b1, 1'b0);
    try_exp("R7 -2^31-ulp", 32'hCF00_0001, 2'b11, 32'h8000_0000, 1'b1, 1'b0);
    // R8 range edges
    try_exp("R8 -2^31", 32'hCF00_0000, 2'b00, 32'h8000_0000, 1'b0, 1'b0);
    try_exp("R8 max fit", 32'h4EFF_FFFF, 2'b00, 32'h7FFF_FF80, 1'b0, 1'b0);
    // R10 zeros and denormals
    try_exp("R10 -0", 32'h8000_0000, 2'b10, 32'd0, 1'b0, 1'b0);
    try_exp("R10 denorm up", 32'h0000_0001, 2'b10, 32'd1, 1'b0, 1'b1);
    try_exp("R10 denorm down", 32'h0000_0001, 2'b01, 32'd0, 1'b0, 1'b1);
    try_exp("R10 -denorm down", 32'h8000_0001, 2'b01, 32'hFFFF_FFFF, 1'b0, 1'b1);
    try_exp("R10 denorm near", 32'h0040_0000, 2'b00, 32'd0, 1'b0, 1'b1);

    // R9 start while busy is ignored; single done pulse
    set_mode(2'b00);
    @(negedge clk); operand_i = 32'h4020_0000; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); operand_i = 32'h40F8_0000; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    w = 0;
    while (!done_o && w < 60) begin @(negedge clk); w++; end
    check("R9 busy start ignored", result_o, 32'd2);
    seen = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done_o) seen++;
    end
    check("R9 no second done", seen, 0);
    check("R9 result held", result_o, 32'd2);

    // R1 mode captured at start: write during conversion has no effect
    @(negedge clk); operand_i = 32'h4020_0000; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; mode_we_i = 1'b1; mode_i = 2'b10;
    @(negedge clk); mode_we_i = 1'b0;
    w = 0;
    while (!done_o && w < 60) begin @(negedge clk); w++; end
    check("R1 mode latched at start", result_o, 32'd2);

    // random operands in random modes (R2 R3 R4 R5 R6 R7)
    for (int n = 0; n < 300; n++) begin
      md = 2'($urandom_range(0, 3));
      op = {1'($urandom_range(0, 1)), 8'($urandom_range(100, 162)), 23'($urandom)};
      if (n % 5 == 0) op[22:0] = op[22:0] & 23'h7F_0000;
      set_mode(md);
      try_op("R2-R5 random", op, md);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule